// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis Controller

This block drives the local active-low flow-control pin from the fill count of a receive FIFO. When automatic flow control is on, the pin is pulled low to invite the far-end transmitter to send. It is released high once the FIFO count climbs to an upper threshold. It stays released until the count has drained to a separate, lower threshold. Both thresholds are independent of the receive interrupt trigger level. Reception is not stopped when that trigger level is reached: only an interrupt request is raised.

A select bit picks which of the two modem output pins, the request-to-send pin or the terminal-ready pin, carries the automatic flow control. The other pin simply mirrors its own software bit. The block also watches the controlled pin for transitions. When the transition interrupt is enabled, each transition sets a sticky status bit that a status read clears. The enable for that interrupt can only be written while the enhanced-function bit is set.

Top module: `rxfc_hyst_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rts_n` and `dtr_n` are 1, and `rx_irq`, `trn_sts` and `trn_irq` are 0. The transition enable is cleared.
- R2: With `auto_en`=1 and `thr_hi` > `thr_lo`, a `fill_cnt` at or below `thr_lo` drives the controlled pin to 0 on the next clock edge.
- R3: With `auto_en`=1 and `thr_hi` > `thr_lo`, a `fill_cnt` at or above `thr_hi` drives the controlled pin to 1 on the next clock edge.
- R4: With `auto_en`=1 and `thr_lo` < `fill_cnt` < `thr_hi`, the controlled pin keeps its previous level.
- R5: With `auto_en`=1 and `thr_hi` <= `thr_lo`, the controlled pin keeps its last level whatever `fill_cnt` does.
- R6: `pin_sel`=0 puts flow control on `rts_n`, and `pin_sel`=1 puts it on `dtr_n`. On the next edge the other pin equals the inverse of its software bit (`sw_rts` or `sw_dtr`, where 1 means asserted, i.e. pin low).
- R7: With `auto_en`=0, the controlled pin also equals the inverse of its software bit on the next edge. The hysteresis state is cleared, so re-enabling starts with the pin asserted unless the fill count is at or above `thr_hi`.
- R8: `rx_irq` is 1 on the edge after a cycle where `rx_ie`=1, `fill_cnt` != 0 and `fill_cnt` >= `trig_lvl`, and 0 otherwise. Reaching the trigger level does not change the controlled pin.
- R9: An `ier_wr` pulse copies `ier_trn_bit` into the transition enable only when `ext_en`=1. A write while `ext_en`=0 has no effect.
- R10: When the transition enable is 1, `trn_sts` is set on the same edge on which the controlled pin changes level. It stays 1 until a cycle with `sts_rd`=1 clears it. A new transition in that same cycle wins over the clear.
- R11: `trn_irq` is 1 exactly when `trn_sts` is 1 and the transition enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic flow control on |
| pin_sel | input | 1 | 0: flow on rts_n, 1: flow on dtr_n |
| sw_rts | input | 1 | Software request-to-send bit, 1 = assert |
| sw_dtr | input | 1 | Software terminal-ready bit, 1 = assert |
| fill_cnt | input | CW | Current receive FIFO count |
| thr_hi | input | CW | Release threshold |
| thr_lo | input | CW | Re-assert threshold |
| trig_lvl | input | CW | Receive interrupt trigger level |
| rx_ie | input | 1 | Receive-ready interrupt enable |
| ext_en | input | 1 | Enhanced-function bit, unlocks enable write |
| ier_wr | input | 1 | Write strobe for transition enable |
| ier_trn_bit | input | 1 | Data for transition enable |
| sts_rd | input | 1 | Status read, clears trn_sts |
| rts_n | output | 1 | Active-low request-to-send pin |
| dtr_n | output | 1 | Active-low terminal-ready pin |
| rx_irq | output | 1 | Receive-ready interrupt request |
| trn_sts | output | 1 | Sticky pin-transition status |
| trn_irq | output | 1 | Pin-transition interrupt request |

## Verification
The threshold properties take the programmed thresholds and `pin_sel` to be steady around the cycle they judge. The hold property for inverted thresholds further takes `auto_en` to have been on in the previous cycle. The stimulus changes thresholds, select and mode only at quiet points, and then sweeps the fill count. A behavioural model in the bench tracks every output on every clock, so mode changes are also covered outside those properties.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic {
    FLOW_OPEN = 1'b0,
    FLOW_HELD = 1'b1
  } flow_e;

  localparam int PIN_RTS = 0;
  localparam int PIN_DTR = 1;
  localparam int NPINS   = 2;
endpackage

// File: rtl/rxfc_hyst.sv
module rxfc_hyst
  import rxfc_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_en,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] hi,
  input  logic [CW-1:0] lo,
  output flow_e         held_d,
  output flow_e         held_q
);
  logic thr_ok;

  assign thr_ok = (hi > lo);

  always_comb begin
    held_d = held_q;
    if (!auto_en) begin
      held_d = FLOW_OPEN;
    end else if (thr_ok) begin
      if (fill >= hi) begin
        held_d = FLOW_HELD;
      end else if (fill <= lo) begin
        held_d = FLOW_OPEN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= FLOW_OPEN;
    end else begin
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/rxfc_pinmux.sv
module rxfc_pinmux
  import rxfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_sel,
  input  logic  auto_en,
  input  flow_e held,
  input  logic  sw_rts,
  input  logic  sw_dtr,
  output logic  rts_n,
  output logic  dtr_n,
  output logic  toggle
);
  logic [NPINS-1:0] sw_bits;
  logic [NPINS-1:0] pin_d;
  logic [NPINS-1:0] pin_q;

  assign sw_bits[PIN_RTS] = sw_rts;
  assign sw_bits[PIN_DTR] = sw_dtr;

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    logic owns_flow;
    assign owns_flow = (int'(pin_sel) == gi) && auto_en;
    assign pin_d[gi] = owns_flow ? (held == FLOW_HELD) : !sw_bits[gi];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q[gi] <= 1'b1;
      end else begin
        pin_q[gi] <= pin_d[gi];
      end
    end
  end

  assign toggle = (pin_d[pin_sel] != pin_q[pin_sel]);
  assign rts_n  = pin_q[PIN_RTS];
  assign dtr_n  = pin_q[PIN_DTR];
endmodule

// File: rtl/rxfc_irq.sv
module rxfc_irq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] trig,
  input  logic          rx_ie,
  input  logic          ext_en,
  input  logic          ier_wr,
  input  logic          ier_bit,
  input  logic          sts_rd,
  input  logic          toggle,
  output logic          rx_irq,
  output logic          trn_sts,
  output logic          trn_irq
);
  logic trn_en_q;
  logic rx_hit;

  assign rx_hit = rx_ie && (fill != '0) && (fill >= trig);

  always_ff @(posedge clk) begin
    if (rst) begin
      trn_en_q <= 1'b0;
      trn_sts  <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_irq <= rx_hit;
      if (ier_wr && ext_en) begin
        trn_en_q <= ier_bit;
      end
      if (toggle && trn_en_q) begin
        trn_sts <= 1'b1;
      end else if (sts_rd) begin
        trn_sts <= 1'b0;
      end
    end
  end

  assign trn_irq = trn_sts && trn_en_q;
endmodule

// File: rtl/rxfc_hyst_ctrl.sv
module rxfc_hyst_ctrl
  import rxfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          auto_en,
  input  logic          pin_sel,
  input  logic          sw_rts,
  input  logic          sw_dtr,
  input  logic [CW-1:0] fill_cnt,
  input  logic [CW-1:0] thr_hi,
  input  logic [CW-1:0] thr_lo,
  input  logic [CW-1:0] trig_lvl,
  input  logic          rx_ie,
  input  logic          ext_en,
  input  logic          ier_wr,
  input  logic          ier_trn_bit,
  input  logic          sts_rd,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          rx_irq,
  output logic          trn_sts,
  output logic          trn_irq
);
  flow_e held_d;
  flow_e held_q;
  logic  toggle;

  rxfc_hyst #(.CW(CW)) hyst_i (
    .clk     (clk),
    .rst     (rst),
    .auto_en (auto_en),
    .fill    (fill_cnt),
    .hi      (thr_hi),
    .lo      (thr_lo),
    .held_d  (held_d),
    .held_q  (held_q)
  );

  rxfc_pinmux pinmux_i (
    .clk     (clk),
    .rst     (rst),
    .pin_sel (pin_sel),
    .auto_en (auto_en),
    .held    (held_d),
    .sw_rts  (sw_rts),
    .sw_dtr  (sw_dtr),
    .rts_n   (rts_n),
    .dtr_n   (dtr_n),
    .toggle  (toggle)
  );

  rxfc_irq #(.CW(CW)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .fill    (fill_cnt),
    .trig    (trig_lvl),
    .rx_ie   (rx_ie),
    .ext_en  (ext_en),
    .ier_wr  (ier_wr),
    .ier_bit (ier_trn_bit),
    .sts_rd  (sts_rd),
    .toggle  (toggle),
    .rx_irq  (rx_irq),
    .trn_sts (trn_sts),
    .trn_irq (trn_irq)
  );
endmodule

// File: rtl/rxfc_hyst_chk.sv
module rxfc_hyst_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          auto_en,
  input logic          pin_sel,
  input logic          sw_rts,
  input logic          sw_dtr,
  input logic [CW-1:0] fill_cnt,
  input logic [CW-1:0] thr_hi,
  input logic [CW-1:0] thr_lo,
  input logic [CW-1:0] trig_lvl,
  input logic          rx_ie,
  input logic          rts_n,
  input logic          dtr_n,
  input logic          rx_irq,
  input logic          trn_sts,
  input logic          trn_irq
);
  logic sel_pin;
  assign sel_pin = pin_sel ? dtr_n : rts_n;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rts_n && dtr_n && !rx_irq && !trn_sts && !trn_irq));

  assert_low_at_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (auto_en && thr_hi > thr_lo && fill_cnt <= thr_lo)
      |=> (($past(pin_sel) ? dtr_n : rts_n) == 1'b0));

  assert_high_at_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_en && thr_hi > thr_lo && fill_cnt >= thr_hi)
      |=> (($past(pin_sel) ? dtr_n : rts_n) == 1'b1));

  assert_bad_thr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && !$past(rst) && thr_hi <= thr_lo
     && pin_sel == $past(pin_sel))
      |=> $stable(sel_pin));

  assert_manual_pin_R7: assert property (@(posedge clk) disable iff (rst)
    (!auto_en) |=> ($past(pin_sel) ? (dtr_n == !$past(sw_dtr))
                                   : (rts_n == !$past(sw_rts))));

  assert_rx_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_ie && fill_cnt != '0 && fill_cnt >= trig_lvl));

  assert_sts_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(trn_sts) |-> (($past(pin_sel) ? dtr_n : rts_n)
                        != ($past(pin_sel) ? $past(dtr_n) : $past(rts_n))));

  assert_irq_needs_sts_R11: assert property (@(posedge clk) disable iff (rst)
    trn_irq |-> trn_sts);
endmodule

bind rxfc_hyst_ctrl rxfc_hyst_chk #(.CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .auto_en  (auto_en),
  .pin_sel  (pin_sel),
  .sw_rts   (sw_rts),
  .sw_dtr   (sw_dtr),
  .fill_cnt (fill_cnt),
  .thr_hi   (thr_hi),
  .thr_lo   (thr_lo),
  .trig_lvl (trig_lvl),
  .rx_ie    (rx_ie),
  .rts_n    (rts_n),
  .dtr_n    (dtr_n),
  .rx_irq   (rx_irq),
  .trn_sts  (trn_sts),
  .trn_irq  (trn_irq)
);

// File: tb/rxfc_hyst_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxfc_hyst_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_en = 0, pin_sel = 0, sw_rts = 0, sw_dtr = 0;
  logic [CW-1:0] fill_cnt = '0, thr_hi = '0, thr_lo = '0, trig_lvl = '0;
  logic rx_ie = 0, ext_en = 0, ier_wr = 0, ier_trn_bit = 0, sts_rd = 0;
  logic rts_n, dtr_n, rx_irq, trn_sts, trn_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // behavioural expectations
  int m_hold = 0, m_rts = 1, m_dtr = 1, m_rx = 0, m_en = 0, m_sts = 0;

  always #2.5 clk = ~clk;

  rxfc_hyst_ctrl #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .auto_en(auto_en), .pin_sel(pin_sel),
    .sw_rts(sw_rts), .sw_dtr(sw_dtr), .fill_cnt(fill_cnt),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .trig_lvl(trig_lvl),
    .rx_ie(rx_ie), .ext_en(ext_en), .ier_wr(ier_wr),
    .ier_trn_bit(ier_trn_bit), .sts_rd(sts_rd),
    .rts_n(rts_n), .dtr_n(dtr_n), .rx_irq(rx_irq),
    .trn_sts(trn_sts), .trn_irq(trn_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int nh, flow, nr, nd;
    bit chg;
    cycles++;
    if (rst) begin
      started = 1;
      m_hold = 0; m_rts = 1; m_dtr = 1; m_rx = 0; m_en = 0; m_sts = 0;
    end else begin
      nh = m_hold;
      if (!auto_en) nh = 0;
      else if (thr_hi > thr_lo) begin
        if (fill_cnt >= thr_hi) nh = 1;
        else if (fill_cnt <= thr_lo) nh = 0;
      end
      flow = auto_en ? nh : (pin_sel ? int'(!sw_dtr) : int'(!sw_rts));
      nr = pin_sel ? int'(!sw_rts) : flow;
      nd = pin_sel ? flow : int'(!sw_dtr);
      chg = pin_sel ? (nd != m_dtr) : (nr != m_rts);
      if (chg && m_en == 1) m_sts = 1;
      else if (sts_rd) m_sts = 0;
      if (ier_wr && ext_en) m_en = int'(ier_trn_bit);
      m_rx = (rx_ie && fill_cnt != 0 && fill_cnt >= trig_lvl) ? 1 : 0;
      m_hold = nh; m_rts = nr; m_dtr = nd;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(int'(rts_n) == m_rts, "R6 rts_n model", int'(rts_n), m_rts);
      chk(int'(dtr_n) == m_dtr, "R6 dtr_n model", int'(dtr_n), m_dtr);
      chk(int'(rx_irq) == m_rx, "R8 rx_irq model", int'(rx_irq), m_rx);
      chk(int'(trn_sts) == m_sts, "R10 trn_sts model", int'(trn_sts), m_sts);
      chk(int'(trn_irq) == (m_sts & m_en), "R11 trn_irq model", int'(trn_irq), m_sts & m_en);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input int f);
    fill_cnt = CW'(f);
    tick();
  endtask

  task automatic wr_en(input bit ext, input bit v);
    ext_en = ext; ier_trn_bit = v; ier_wr = 1;
    tick();
    ier_wr = 0; ext_en = 0;
  endtask

  initial begin
    tick(3);
    chk(rts_n == 1 && dtr_n == 1, "R1 pins in reset", int'({rts_n, dtr_n}), 3);
    chk(!rx_irq && !trn_sts && !trn_irq, "R1 irqs in reset", int'({rx_irq, trn_sts, trn_irq}), 0);
    rst = 0;
    tick();
    chk(rts_n == 1 && dtr_n == 1, "R1 pins after reset", int'({rts_n, dtr_n}), 3);

    thr_hi = 40; thr_lo = 10; trig_lvl = 20;
    auto_en = 1; sw_dtr = 1;
    put(0);
    chk(rts_n == 0, "R2 assert at empty", rts_n, 0);
    chk(dtr_n == 0, "R6 unselected pin follows sw_dtr", dtr_n, 0);
    put(19);
    rx_ie = 1; tick();
    chk(rx_irq == 0, "R8 below trigger", rx_irq, 0);
    put(20);
    chk(rx_irq == 1, "R8 at trigger", rx_irq, 1);
    chk(rts_n == 0, "R8 trigger leaves pin", rts_n, 0);
    put(39);
    chk(rts_n == 0, "R4 below upper", rts_n, 0);
    put(40);
    chk(rts_n == 1, "R3 release at upper", rts_n, 1);
    put(25);
    chk(rts_n == 1, "R4 held in band", rts_n, 1);
    put(11);
    chk(rts_n == 1, "R4 held above lower", rts_n, 1);
    put(10);
    chk(rts_n == 0, "R2 reassert at lower", rts_n, 0);

    wr_en(0, 1);
    put(45);
    chk(trn_sts == 0, "R9 locked enable write ignored", trn_sts, 0);
    put(0);
    wr_en(1, 1);
    put(50);
    chk(rts_n == 1 && trn_sts == 1, "R10 status with edge", int'({rts_n, trn_sts}), 3);
    chk(trn_irq == 1, "R11 irq raised", trn_irq, 1);
    tick(3);
    chk(trn_sts == 1, "R10 sticky", trn_sts, 1);
    sts_rd = 1; tick(); sts_rd = 0;
    chk(trn_sts == 0, "R10 read clears", trn_sts, 0);
    fill_cnt = 0; sts_rd = 1; tick(); sts_rd = 0;
    chk(trn_sts == 1, "R10 set beats clear", trn_sts, 1);
    wr_en(1, 0);
    chk(trn_sts == 1 && trn_irq == 0, "R11 disabled mask", int'({trn_sts, trn_irq}), 2);
    sts_rd = 1; tick(); sts_rd = 0;

    pin_sel = 1; sw_rts = 1;
    put(0);
    chk(rts_n == 0 && dtr_n == 0, "R6 dtr selected", int'({rts_n, dtr_n}), 0);
    put(40);
    chk(dtr_n == 1 && rts_n == 0, "R6 flow on dtr_n", int'({rts_n, dtr_n}), 1);
    sw_rts = 0; tick();
    chk(rts_n == 1, "R6 rts_n follows sw_rts", rts_n, 1);

    thr_hi = 5; thr_lo = 30;
    for (int f = 0; f <= 60; f += 6) put(f);
    chk(dtr_n == 1, "R5 bad thresholds hold high", dtr_n, 1);
    thr_hi = 40; thr_lo = 10; put(0);
    thr_hi = 5; thr_lo = 30;
    for (int f = 60; f >= 0; f -= 5) put(f);
    chk(dtr_n == 0, "R5 bad thresholds hold low", dtr_n, 0);

    auto_en = 0; sw_dtr = 0; put(50);
    chk(dtr_n == 1, "R7 manual deassert", dtr_n, 1);
    sw_dtr = 1; tick();
    chk(dtr_n == 0, "R7 manual assert", dtr_n, 0);
    thr_hi = 40; thr_lo = 10; fill_cnt = 25; auto_en = 1; tick();
    chk(dtr_n == 0, "R7 hold cleared on re-enable", dtr_n, 0);

    rst = 1; tick(); rst = 0; tick();
    chk(rts_n == 1 || auto_en, "R1 second reset", rts_n, 1);
    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule